// File: doc/BRIEF.md
# Multichannel Voltage Limit Monitor

This block watches the digital output of a multiplexed voltage converter. Each valid sample arrives as an unsigned 8-bit code (one count is 8 mV, so the range is 0 to 2.040 V) together with the index of the channel it was taken from. Every channel has its own lower and upper limit. A sample outside that window raises a sticky alarm bit for its channel. The block also keeps the most recent code of every channel for readback, together with a flag that marks channels whose input is internally halved. It does no unit conversion of its own.

A simple register port reaches the limits, the stored codes and the alarm vector. Reading the alarm vector clears those bits whose channel is back inside its window. Limits hold only their upper six bits, so a limit moves in steps of 4 counts (32 mV), while samples keep their full 8-bit resolution. The channel count is 9, plus 2 internal channels when a parameter enables them.

Top module: `vmon_top`

## Requirements
- R1: A sample with `smp_valid` high and an index below the channel count stores its code. A read at region 2 (`reg_addr[5:4]` = 2, channel in `reg_addr[3:0]`) returns that code in bits 7:0.
- R2: Limit registers (region 0 = lower, region 1 = upper) keep bits 7:2 of the written byte. Bits 1:0 always read as zero, and the values written to them are ignored.
- R3: A sample raises its channel's alarm when its code is strictly below the lower limit or strictly above the upper limit. A code equal to either limit raises nothing.
- R4: After reset every lower limit is 0x00, every upper limit is 0xFC, all alarms are clear and all stored codes are 0. Codes 0x00 to 0xFC then raise no alarm, and codes 0xFD to 0xFF exceed the upper limit.
- R5: With `EXTRA_INT`=1 there are 11 channels (indices 0 to 10), otherwise 9. For an index at or above the channel count, samples and limit writes are ignored, and reads of regions 0 to 2 return 0.
- R6: Bit 8 of a region-2 read is the halved-input flag. It is 1 for channel 0, and also for channels 9 and 10 when the extra channels are enabled. It is 0 for all other channels.
- R7: An alarm bit stays set until the alarm vector is read, even if later samples are back inside the window.
- R8: A read of region 3 returns the alarm vector, with bit c for channel c. The read clears each bit whose channel's latest sample (counting a sample taken at the same edge) is inside the window, and keeps the bits whose latest sample still violates. A violation sampled at the same edge as the read is missing from the returned value but stays set.
- R9: When a limit write and a sample for the same channel meet at one clock edge, the write takes effect first and the sample is compared against the new limit.
- R10: Read data appears on `reg_rdata` in the cycle after `reg_rd` is sampled high and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | A sample is present this cycle |
| smp_chan | input | 4 | Channel index of the sample |
| smp_code | input | 8 | Unsigned sample code |
| reg_wr | input | 1 | Register write strobe (regions 0 and 1) |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 6 | Bits 5:4 region, bits 3:0 channel |
| reg_wdata | input | 8 | Limit write data |
| reg_rdata | output | 16 | Registered read data |

## Verification
A wrong limit register shows at the next readback of that limit. It also shows in the alarm bit that the following sample sweep raises or leaves clear at exactly the boundary codes. Because every sample is followed by an alarm read, a wrong stored condition or a wrong sticky bit shows within two cycles of the sample that exposes it. The same holds for a clear that drops too much or too little. Faults in the same-edge write-and-compare ordering and the read-with-sample ordering are driven directly, so each one shows on the first read that follows it.

// File: rtl/vmon_pkg.sv
// Shared types and helpers for the voltage limit monitor.
// Assumes unsigned sample codes and limits that drop their low LIM_DROP bits.
package vmon_pkg;
    localparam int CODE_W   = 8;
    localparam int LIM_DROP = 2;
    localparam int KEEP_W   = CODE_W - LIM_DROP;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [KEEP_W-1:0] lim_t;

    typedef enum logic [1:0] {
        RG_LOW  = 2'd0,
        RG_HIGH = 2'd1,
        RG_CODE = 2'd2,
        RG_STAT = 2'd3
    } region_e;

    localparam lim_t LOW_RST  = '0;
    localparam lim_t HIGH_RST = '1;

    // Restore a stored limit to full code width, low bits zero.
    function automatic code_t lim_widen(lim_t l);
        return {l, {LIM_DROP{1'b0}}};
    endfunction

    // Keep only the stored part of a written limit byte.
    function automatic lim_t lim_trim(code_t v);
        return v[CODE_W-1:LIM_DROP];
    endfunction

    // True for channels whose input is internally halved.
    function automatic logic is_halved(int idx, int base, int extra);
        return (idx == 0) || ((extra != 0) && (idx >= base) && (idx < base + 2));
    endfunction
endpackage

// File: rtl/vmon_limit_bank.sv
// Per-channel lower and upper limit storage.
// Holds only the kept upper bits of each limit. Offers a read view for the
// register port and a compare view for the sample path. The compare view
// forwards a same-edge write to the sampled channel so the new limit is used.
// Assumes wr_idx and rd_idx may be out of range; such accesses do nothing or
// return zero.
module vmon_limit_bank
    import vmon_pkg::*;
#(
    parameter int NCH  = 11,
    parameter int CH_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_low,
    input  logic            wr_high,
    input  logic [CH_W-1:0] wr_idx,
    input  lim_t            wr_lim,
    input  logic [CH_W-1:0] rd_idx,
    output code_t           rd_low,
    output code_t           rd_high,
    input  logic [CH_W-1:0] smp_idx,
    output code_t           eff_low,
    output code_t           eff_high
);
    lim_t low_q  [NCH];
    lim_t high_q [NCH];

    // Limit registers: reset to an open window, update on addressed writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                low_q[c]  <= LOW_RST;
                high_q[c] <= HIGH_RST;
            end
        end else begin
            for (int c = 0; c < NCH; c++) begin
                if (wr_low && (wr_idx == CH_W'(c)))
                    low_q[c] <= wr_lim;
                if (wr_high && (wr_idx == CH_W'(c)))
                    high_q[c] <= wr_lim;
            end
        end
    end

    // Register-port view of the addressed channel's limits.
    always_comb begin
        rd_low  = '0;
        rd_high = '0;
        if (int'(rd_idx) < NCH) begin
            rd_low  = lim_widen(low_q[rd_idx]);
            rd_high = lim_widen(high_q[rd_idx]);
        end
    end

    // Compare view with same-edge write forwarding.
    always_comb begin
        eff_low  = '0;
        eff_high = '0;
        if (int'(smp_idx) < NCH) begin
            eff_low  = lim_widen(low_q[smp_idx]);
            eff_high = lim_widen(high_q[smp_idx]);
            if (wr_low && (wr_idx == smp_idx))
                eff_low = lim_widen(wr_lim);
            if (wr_high && (wr_idx == smp_idx))
                eff_high = lim_widen(wr_lim);
        end
    end
endmodule

// File: rtl/vmon_window_cmp.sv
// Window comparator: flags a code strictly outside [low, high].
// Assumes unsigned operands; equality with a limit is inside the window.
module vmon_window_cmp
    import vmon_pkg::*;
(
    input  code_t code,
    input  code_t low,
    input  code_t high,
    output logic  below,
    output logic  above,
    output logic  viol
);
    // Strict comparisons on both sides.
    always_comb begin
        below = code < low;
        above = code > high;
        viol  = below | above;
    end
endmodule

// File: rtl/vmon_alarm_track.sv
// Per-channel condition, sticky alarm and last-code storage.
// A sample sets the channel's condition and, on violation, its alarm.
// A status read keeps only the alarms whose current condition is still true;
// a sample at the same edge counts as the current condition.
// Assumes smp_idx may be out of range; such samples are dropped.
module vmon_alarm_track
    import vmon_pkg::*;
#(
    parameter int NCH  = 11,
    parameter int CH_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            smp_valid,
    input  logic [CH_W-1:0] smp_idx,
    input  code_t           smp_code,
    input  logic            viol,
    input  logic            stat_rd,
    input  logic [CH_W-1:0] rd_idx,
    output logic [NCH-1:0]  alarm_q,
    output logic [NCH-1:0]  cond_q,
    output code_t           rd_code
);
    code_t          code_q [NCH];
    logic [NCH-1:0] hit;
    logic [NCH-1:0] set_now;
    logic [NCH-1:0] cond_nx;
    logic [NCH-1:0] alarm_nx;

    // One-hot decode of the sampled channel.
    always_comb begin
        for (int c = 0; c < NCH; c++)
            hit[c] = smp_valid && (smp_idx == CH_W'(c));
    end

    // Next condition and next alarm vectors.
    always_comb begin
        set_now = hit & {NCH{viol}};
        cond_nx = (cond_q & ~hit) | set_now;
        if (stat_rd)
            alarm_nx = (alarm_q & cond_nx) | set_now;
        else
            alarm_nx = alarm_q | set_now;
    end

    // State registers for condition and alarm.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cond_q  <= '0;
            alarm_q <= '0;
        end else begin
            cond_q  <= cond_nx;
            alarm_q <= alarm_nx;
        end
    end

    // Last-code store per channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++)
                code_q[c] <= '0;
        end else begin
            for (int c = 0; c < NCH; c++)
                if (hit[c])
                    code_q[c] <= smp_code;
        end
    end

    // Readback of the addressed channel's last code.
    always_comb begin
        rd_code = '0;
        if (int'(rd_idx) < NCH)
            rd_code = code_q[rd_idx];
    end
endmodule

// File: rtl/vmon_regif.sv
// Register port decode and registered read mux.
// Region in the top two address bits, channel index below. Read data is
// captured on the read strobe and held until the next read.
// Assumes NCH fits in DATA_W and that CODE_W + 1 fits in DATA_W.
module vmon_regif
    import vmon_pkg::*;
#(
    parameter int NCH       = 11,
    parameter int CH_W      = 4,
    parameter int BASE_CH   = 9,
    parameter int EXTRA_INT = 1,
    parameter int DATA_W    = 16,
    localparam int ADDR_W   = CH_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    output logic              wr_low,
    output logic              wr_high,
    output logic              stat_rd,
    output logic [CH_W-1:0]   idx,
    input  code_t             rd_low,
    input  code_t             rd_high,
    input  code_t             rd_code,
    input  logic [NCH-1:0]    alarm_vec,
    output logic [DATA_W-1:0] reg_rdata
);
    region_e           region;
    logic              scale;
    logic [DATA_W-1:0] rd_mux;

    // Address field split and strobe decode.
    always_comb begin
        region  = region_e'(reg_addr[ADDR_W-1:ADDR_W-2]);
        idx     = reg_addr[CH_W-1:0];
        wr_low  = reg_wr && (region == RG_LOW);
        wr_high = reg_wr && (region == RG_HIGH);
        stat_rd = reg_rd && (region == RG_STAT);
        scale   = (int'(idx) < NCH) && is_halved(int'(idx), BASE_CH, EXTRA_INT);
    end

    // Read data selection by region.
    always_comb begin
        case (region)
            RG_LOW:  rd_mux = DATA_W'(rd_low);
            RG_HIGH: rd_mux = DATA_W'(rd_high);
            RG_CODE: rd_mux = DATA_W'({scale, rd_code});
            default: rd_mux = DATA_W'(alarm_vec);
        endcase
    end

    // Read data register, loaded on each read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            reg_rdata <= '0;
        else if (reg_rd)
            reg_rdata <= rd_mux;
    end
endmodule

// File: rtl/vmon_top.sv
// Multichannel voltage limit monitor, top level.
// Joins limit storage, window compare, alarm tracking and the register port.
// Assumes one sample per cycle at most and a single register access per cycle.
module vmon_top
    import vmon_pkg::*;
#(
    parameter int BASE_CH   = 9,
    parameter int EXTRA_INT = 1,
    parameter int DATA_W    = 16,
    localparam int NCH      = BASE_CH + ((EXTRA_INT != 0) ? 2 : 0),
    localparam int CH_W     = $clog2(NCH),
    localparam int ADDR_W   = CH_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [CH_W-1:0]   smp_chan,
    input  logic [CODE_W-1:0] smp_code,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [CODE_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata
);
    logic            wr_low;
    logic            wr_high;
    logic            stat_rd;
    logic [CH_W-1:0] idx;
    code_t           rd_low;
    code_t           rd_high;
    code_t           rd_code;
    code_t           eff_low;
    code_t           eff_high;
    logic            below;
    logic            above;
    logic            viol;
    logic            smp_ok;
    logic [NCH-1:0]  alarm_vec;
    logic [NCH-1:0]  cond_vec;
    lim_t            wr_lim;
    logic            unused_sig;

    // Drop the limit byte's unkept bits and gate out-of-range samples.
    always_comb begin
        wr_lim     = lim_trim(reg_wdata);
        smp_ok     = smp_valid && (int'(smp_chan) < NCH);
        unused_sig = ^{reg_wdata[LIM_DROP-1:0], below, above, cond_vec};
    end

    vmon_regif #(
        .NCH(NCH), .CH_W(CH_W), .BASE_CH(BASE_CH),
        .EXTRA_INT(EXTRA_INT), .DATA_W(DATA_W)
    ) u_regif (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .wr_low(wr_low), .wr_high(wr_high),
        .stat_rd(stat_rd), .idx(idx), .rd_low(rd_low), .rd_high(rd_high),
        .rd_code(rd_code), .alarm_vec(alarm_vec), .reg_rdata(reg_rdata)
    );

    vmon_limit_bank #(.NCH(NCH), .CH_W(CH_W)) u_lim (
        .clk(clk), .rst_n(rst_n), .wr_low(wr_low), .wr_high(wr_high),
        .wr_idx(idx), .wr_lim(wr_lim), .rd_idx(idx), .rd_low(rd_low),
        .rd_high(rd_high), .smp_idx(smp_chan), .eff_low(eff_low),
        .eff_high(eff_high)
    );

    vmon_window_cmp u_cmp (
        .code(smp_code), .low(eff_low), .high(eff_high),
        .below(below), .above(above), .viol(viol)
    );

    vmon_alarm_track #(.NCH(NCH), .CH_W(CH_W)) u_track (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_ok), .smp_idx(smp_chan),
        .smp_code(smp_code), .viol(viol), .stat_rd(stat_rd), .rd_idx(idx),
        .alarm_q(alarm_vec), .cond_q(cond_vec), .rd_code(rd_code)
    );
endmodule

// File: rtl/vmon_chk.sv
// Property checker for vmon_top, attached by bind below.
// Observes the ports plus the alarm and condition vectors.
module vmon_chk #(
    parameter int NCH    = 11,
    parameter int CH_W   = 4,
    parameter int DATA_W = 16,
    localparam int ADDR_W = CH_W + 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              smp_valid,
    input logic [CH_W-1:0]   smp_chan,
    input logic [7:0]        smp_code,
    input logic              reg_rd,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_rdata,
    input logic [NCH-1:0]    alarm_vec,
    input logic [NCH-1:0]    cond_vec
);
    logic [1:0]      region;
    logic [CH_W-1:0] aidx;
    assign region = reg_addr[ADDR_W-1:ADDR_W-2];
    assign aidx   = reg_addr[CH_W-1:0];

    assert_limit_lsb_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !region[1]) |=> (reg_rdata[1:0] == 2'b00));

    assert_top_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && (int'(smp_chan) < NCH) && (smp_code > 8'hFC))
        |=> (((alarm_vec >> $past(smp_chan)) & NCH'(1)) != '0));

    assert_absent_chan_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && (region != 2'd3) && (int'(aidx) >= NCH)) |=> (reg_rdata == '0));

    assert_scale_ch0_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && (region == 2'd2) && (aidx == '0)) |=> reg_rdata[8]);

    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rd && (region == 2'd3)) |=> ((alarm_vec & $past(alarm_vec)) == $past(alarm_vec)));

    assert_read_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && (region == 2'd3) && !smp_valid)
        |=> (alarm_vec == ($past(alarm_vec) & $past(cond_vec))));
endmodule

bind vmon_top vmon_chk #(.NCH(NCH), .CH_W(CH_W), .DATA_W(DATA_W)) u_vmon_chk (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_chan(smp_chan),
    .smp_code(smp_code), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_rdata(reg_rdata), .alarm_vec(alarm_vec), .cond_vec(cond_vec)
);

// File: tb/tb_vmon_top.sv
// Self-checking bench for vmon_top with 11 channels.
module tb_vmon_top;
    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 11;
    localparam int WD_CYCLES  = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [3:0]  smp_chan = '0;
    logic [7:0]  smp_code = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [15:0] reg_rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    int          m_low  [16];
    int          m_high [16];
    int          m_code [16];
    logic [15:0] m_alarm = '0;
    logic [15:0] m_cond  = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vmon_top dut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_chan(smp_chan),
        .smp_code(smp_code), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    function automatic logic [5:0] adr(int r, int c);
        return {2'(r), 4'(c)};
    endfunction

    function automatic bit halved(int c);
        return (c == 0) || (c == 9) || (c == 10);
    endfunction

    function automatic logic [15:0] exp_read(logic [5:0] a);
        int r = int'(a[5:4]);
        int c = int'(a[3:0]);
        if (r == 3) return m_alarm;
        if (c >= NCH) return 16'h0;
        if (r == 0) return 16'(m_low[c]);
        if (r == 1) return 16'(m_high[c]);
        return 16'((halved(c) ? 256 : 0) + m_code[c]);
    endfunction

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock of stimulus; the model applies write, then sample, then read.
    task automatic step(string tag, bit wr, bit rd, logic [5:0] a, logic [7:0] wd,
                        bit sv, logic [3:0] sc, logic [7:0] code);
        logic [15:0] exp;
        int c;
        bit v;
        exp = exp_read(a);
        c = int'(a[3:0]);
        if (wr && c < NCH) begin
            if (a[5:4] == 2'd0) m_low[c]  = int'(wd & 8'hFC);
            if (a[5:4] == 2'd1) m_high[c] = int'(wd & 8'hFC);
        end
        if (sv && int'(sc) < NCH) begin
            v = (int'(code) < m_low[sc]) || (int'(code) > m_high[sc]);
            m_code[sc] = int'(code);
            m_cond[sc] = v;
            if (v) m_alarm[sc] = 1'b1;
        end
        if (rd && a[5:4] == 2'd3) m_alarm = m_alarm & m_cond;
        reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = wd;
        smp_valid = sv; smp_chan = sc; smp_code = code;
        @(negedge clk);
        reg_wr = 0; reg_rd = 0; smp_valid = 0;
        if (rd) check(tag, reg_rdata, exp);
    endtask

    task automatic rd(string tag, int r, int c);
        step(tag, 0, 1, adr(r, c), 8'h00, 0, 4'h0, 8'h00);
    endtask

    task automatic wr(int r, int c, int v);
        step("", 1, 0, adr(r, c), 8'(v), 0, 4'h0, 8'h00);
    endtask

    task automatic smp(int c, int code);
        step("", 0, 0, 6'h00, 8'h00, 1, 4'(c), 8'(code));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        for (int c = 0; c < 16; c++) begin
            m_low[c] = 0; m_high[c] = 252; m_code[c] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 / R5 / R6: reset contents, including an absent channel.
        for (int c = 0; c < 12; c++) begin
            rd("R4_low_reset", 0, c);
            rd("R4_high_reset", 1, c);
            rd("R6_code_scale_reset", 2, c);
        end
        rd("R4_alarm_reset", 3, 0);

        // R4: reset window boundary; R7 sticky; R8 clear.
        smp(1, 8'hFC); rd("R4_fc_no_alarm", 3, 0);
        smp(1, 8'hFD); rd("R4_fd_alarm", 3, 0);
        rd("R8_kept_while_violating", 3, 0);
        smp(1, 8'h80); rd("R7_sticky_after_recovery", 3, 0);
        rd("R8_cleared", 3, 0);

        // R2: every limit byte written, low bits dropped.
        for (int v = 0; v < 256; v++) begin
            wr(0, 3, v); rd("R2_low_mask", 0, 3);
            wr(1, 5, v); rd("R2_high_mask", 1, 5);
        end
        wr(0, 3, 0); wr(1, 5, 8'hFC);

        // R3 / R1 / R7 / R8: full code sweep on every channel.
        for (int c = 0; c < NCH; c++) begin
            int lo = (c * 12 + 21) & 8'hFC;
            wr(0, c, c * 12 + 21);
            wr(1, c, (lo + 60 + c * 4) | 2);
            rd("R3_high_readback", 1, c);
            rd("R8_pre_sweep_clear", 3, 0);
            for (int code = 0; code < 256; code++) begin
                smp(c, code);
                rd("R3_window_sweep", 3, 0);
                if (code % 64 == 5) rd("R1_code_readback", 2, c);
            end
        end

        // R9: same-edge write and sample on one channel.
        wr(0, 2, 8'h40); wr(1, 2, 8'hFC);
        smp(2, 8'h60); rd("R9_setup_clear", 3, 0); rd("R9_setup_clear2", 3, 0);
        step("", 1, 0, adr(0, 2), 8'h80, 1, 4'd2, 8'h60);
        rd("R9_new_low_used", 3, 0);
        wr(0, 4, 0); wr(1, 4, 8'hFC); smp(4, 8'h60);
        rd("R9_setup4", 3, 0); rd("R9_setup4b", 3, 0);
        step("", 1, 0, adr(1, 4), 8'h40, 1, 4'd4, 8'h60);
        rd("R9_new_high_used", 3, 0);
        step("", 1, 0, adr(0, 6), 8'hFF, 1, 4'd7, 8'h60);
        rd("R9_other_channel", 3, 0);
        rd("R9_limit_after", 0, 6);

        // R8: sample at the same edge as a status read.
        wr(0, 8, 8'h20); smp(8, 8'h30); rd("R8_setup", 3, 0); rd("R8_setup2", 3, 0);
        step("R8_read_with_sample", 0, 1, adr(3, 0), 8'h00, 1, 4'd8, 8'h00);
        rd("R8_same_edge_kept", 3, 0);

        // R5: absent channels ignore samples and writes.
        smp(11, 8'hFF); smp(15, 8'h00);
        rd("R5_absent_sample_ignored", 3, 0);
        wr(0, 12, 8'hF0); rd("R5_absent_write_ignored", 0, 12);
        rd("R5_absent_code", 2, 11);

        // R10: read data holds between reads.
        rd("R10_read", 1, 4);
        smp(3, 8'h11); wr(1, 4, 8'h88);
        check("R10_hold", reg_rdata, 16'h0040);

        finish_run();
    end
endmodule